// File: doc/BRIEF.md
# Two-Level Priority Interrupt Controller

This block collects one non-maskable request, six external interrupt pins (active low) and a parameterised set of internal module requests, and hands the processor a single winning vector number. Each request source belongs to a group with one priority bit, which places it in the low level (bit clear) or the high level (bit set). The high level beats the low level, and inside a level the order is fixed, lowest vector number first. The non-maskable request beats everything and ignores the mask bits.

Two processor mask bits, `cpu_i` and `cpu_ui`, and a mode bit, `mode_ue`, decide which levels may be taken. With `mode_ue` high, `cpu_i` masks every maskable source and `cpu_ui` has no effect. With `mode_ue` low, `cpu_i` alone masks the low level, and `cpu_i` together with `cpu_ui` masks both levels.

The chosen vector leaves on a valid/ready channel. `int_valid` and `int_vector` come from registers. The processor accepts a vector by raising `int_ready`. While the presented source is still pending and still allowed, the vector stays frozen until it is accepted, even if a higher-priority source arrives. If the presented source is withdrawn or becomes masked, the register reloads with the current winner, or drops `int_valid` if there is none. Back-pressure is therefore free: the processor may hold `int_ready` low for any length of time. A handshake always leaves one idle cycle before the next vector.

Top module: `irq_prio_ctrl`

## Requirements
- R1: After reset, `int_valid` is 0 and the priority, enable, sense and flag registers all read 0.
- R2: A falling edge on `nmi_n` presents vector 7 whatever the states of `cpu_i`, `cpu_ui` and `mode_ue`. Accepting that vector clears the pending non-maskable request, and a pin held low does not raise it again.
- R3: Sense bit k selects the mode for pin k. When the bit is 0 (level mode), flag k is set on every cycle that the synchronised pin is low. When the bit is 1 (edge mode), flag k is set only on a high-to-low transition, so a pin held low after its flag is cleared leaves the flag clear.
- R4: A configuration write with `cfg_sel`=3 clears each flag whose data bit is 0. Data bits that are 1 leave their flags unchanged.
- R5: Flags are set whatever the enable bits say, but IRQ k is presented only while enable bit k (`cfg_sel`=1) is 1.
- R6: Priority register (`cfg_sel`=0) bits 0 to 3 rank IRQ0, IRQ1, IRQ2/3 and IRQ4/5. Bit 4+g ranks module sources 2g and 2g+1. A pending source whose bit is 1 wins over any pending source whose bit is 0.
- R7: Vector numbers are fixed: the non-maskable request is 7, IRQ k is 12+k, and module source j is 24+j. Within a level, the smallest vector number wins.
- R8: With `mode_ue`=1 and `cpu_i`=1, no maskable vector is presented at any level. Clearing `cpu_i` lets the pending source through.
- R9: With `mode_ue`=0, `cpu_i`=1 and `cpu_ui`=0, only high-level sources are presented. With `cpu_i`=1 and `cpu_ui`=1, nothing maskable is presented. With `cpu_i`=0, everything is presented.
- R10: While `int_valid` is 1, `int_ready` is 0 and the presented source stays pending and allowed, `int_vector` holds its value, even if a higher-priority source becomes pending.
- R11: If the presented source is withdrawn or becomes masked before acceptance, on the next cycle the output shows the current winner, or `int_valid` is 0 if there is none.
- R12: A module request raised before a clock edge is presented after that edge. A pin edge is presented four edges later. After a handshake, `int_valid` is 0 for one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| nmi_n | input | 1 | Non-maskable request pin, falling-edge sensed |
| irq_n | input | 6 | External interrupt pins, active low |
| mod_req | input | 8 | Internal module request levels |
| cpu_i | input | 1 | Processor primary mask bit |
| cpu_ui | input | 1 | Processor secondary mask bit |
| mode_ue | input | 1 | 1: secondary bit is a plain user bit; 0: it is a second mask level |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 2 | Register select: 0 priority, 1 enable, 2 sense, 3 flag clear |
| cfg_wdata | input | 8 | Configuration write data |
| int_valid | output | 1 | A vector is being offered |
| int_vector | output | 8 | Offered vector number |
| int_ready | input | 1 | Processor accepts the offered vector |
| prio_q | output | 8 | Priority register contents |
| irq_en_q | output | 6 | Enable register contents |
| irq_edge_q | output | 6 | Sense register contents (1 = edge) |
| irq_flag_q | output | 6 | IRQ pending flags |

## Verification
Each result appears after a fixed number of clock edges. A module request or a mask change shows on `int_valid`/`int_vector` one edge later. A pin change sets its flag three edges later and reaches the vector output on the fourth edge. A configuration write takes effect at the edge that captures it. The bench drives inputs and samples outputs on falling edges. After each stimulus it advances exactly that many rising edges before it compares, and it waits the same way when checking that something does not appear.

// File: rtl/irq_prio_pkg.sv
package irq_prio_pkg;
  localparam int VEC_W        = 8;
  localparam int NMI_VEC      = 7;
  localparam int IRQ_VEC_BASE = 12;
  localparam int MOD_VEC_BASE = 24;

  typedef enum logic [1:0] {
    CFG_PRIO   = 2'd0,
    CFG_ENABLE = 2'd1,
    CFG_SENSE  = 2'd2,
    CFG_STATUS = 2'd3
  } cfg_sel_e;

  // Pins 0 and 1 rank alone, later pins rank in pairs.
  function automatic int irq_prio_bit(input int k);
    return (k < 2) ? k : 2 + (k - 2) / 2;
  endfunction
endpackage

// File: rtl/irq_sense_chan.sv
module irq_sense_chan #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_n,
  input  logic edge_mode,
  input  logic wr_status,
  input  logic wr_bit,
  input  logic ack_clr,
  output logic flag
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic prev_q;
  logic pin_s, set_now, keep;

  assign pin_s   = sync_q[SYNC_STAGES-1];
  assign set_now = edge_mode ? (prev_q & ~pin_s) : ~pin_s;
  assign keep    = ~(wr_status & ~wr_bit) & ~ack_clr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '1;
      prev_q <= 1'b1;
      flag   <= 1'b0;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], pin_n};
      prev_q <= pin_s;
      flag   <= set_now | (flag & keep);
    end
  end

  // R3
  level_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!edge_mode && !pin_s) |=> flag);

  // R4
  write_one_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_status && wr_bit && flag && !ack_clr) |=> flag);
endmodule

// File: rtl/irq_prio_arb.sv
module irq_prio_arb #(
  parameter int N     = 15,
  parameter int IDX_W = 4
) (
  input  logic [N-1:0]     pend,
  input  logic [N-1:0]     hi,
  input  logic             lo_ok,
  input  logic             hi_ok,
  output logic [N-1:0]     allowed,
  output logic             win_valid,
  output logic [IDX_W-1:0] win_idx
);
  logic [N-1:0] hi_eff;
  logic hi_any, lo_any;
  logic [IDX_W-1:0] hi_idx, lo_idx;

  // Index 0 is the non-maskable source: always high, never masked.
  genvar g;
  generate
    for (g = 0; g < N; g++) begin : g_allow
      if (g == 0) begin : g_nmi
        assign hi_eff[g]  = 1'b1;
        assign allowed[g] = pend[g];
      end else begin : g_mask
        assign hi_eff[g]  = hi[g];
        assign allowed[g] = pend[g] & (hi[g] ? hi_ok : lo_ok);
      end
    end
  endgenerate

  always_comb begin
    hi_any = 1'b0;
    lo_any = 1'b0;
    hi_idx = '0;
    lo_idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (allowed[i] && hi_eff[i]) begin
        hi_any = 1'b1;
        hi_idx = IDX_W'(i);
      end
      if (allowed[i] && !hi_eff[i]) begin
        lo_any = 1'b1;
        lo_idx = IDX_W'(i);
      end
    end
    win_valid = hi_any | lo_any;
    win_idx   = hi_any ? hi_idx : lo_idx;
  end
endmodule

// File: rtl/irq_vec_hold.sv
module irq_vec_hold #(
  parameter int N     = 15,
  parameter int IDX_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N-1:0]     allowed,
  input  logic             win_valid,
  input  logic [IDX_W-1:0] win_idx,
  input  logic             ready,
  output logic             out_valid,
  output logic [IDX_W-1:0] out_idx,
  output logic             handshake
);
  logic held_live;

  assign held_live = (int'(out_idx) < N) ? allowed[out_idx] : 1'b0;
  assign handshake = out_valid & ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_idx   <= '0;
    end else if (handshake) begin
      out_valid <= 1'b0;
    end else if (!out_valid || !held_live) begin
      out_valid <= win_valid;
      out_idx   <= win_idx;
    end
  end

  // R10
  hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !ready && held_live) |=> (out_valid && $stable(out_idx)));

  // R12
  hs_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    handshake |=> !out_valid);
endmodule

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl
  import irq_prio_pkg::*;
#(
  parameter int NIRQ        = 6,
  parameter int NSRC        = 8,
  parameter int SRC_PER_GRP = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  nmi_n,
  input  logic [NIRQ-1:0]       irq_n,
  input  logic [NSRC-1:0]       mod_req,
  input  logic                  cpu_i,
  input  logic                  cpu_ui,
  input  logic                  mode_ue,
  input  logic                  cfg_we,
  input  logic [1:0]            cfg_sel,
  input  logic [7:0]            cfg_wdata,
  output logic                  int_valid,
  output logic [VEC_W-1:0]      int_vector,
  input  logic                  int_ready,
  output logic [7:0]            prio_q,
  output logic [NIRQ-1:0]       irq_en_q,
  output logic [NIRQ-1:0]       irq_edge_q,
  output logic [NIRQ-1:0]       irq_flag_q
);
  localparam int NGRP     = NSRC / SRC_PER_GRP;
  localparam int IRQ_GRPS = irq_prio_bit(NIRQ - 1) + 1;
  localparam int PRIO_W   = IRQ_GRPS + NGRP;
  localparam int NALL     = 1 + NIRQ + NSRC;
  localparam int IDX_W    = $clog2(NALL);

  logic [NALL-1:0]  pend, hi, allowed;
  logic             win_valid, handshake, nmi_flag, lo_ok, hi_ok;
  logic [IDX_W-1:0] win_idx, out_idx;
  logic             wr_status;
  cfg_sel_e         sel;

  assign sel       = cfg_sel_e'(cfg_sel);
  assign wr_status = cfg_we && (sel == CFG_STATUS);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prio_q     <= '0;
      irq_en_q   <= '0;
      irq_edge_q <= '0;
    end else if (cfg_we) begin
      case (sel)
        CFG_PRIO:   prio_q     <= cfg_wdata[PRIO_W-1:0];
        CFG_ENABLE: irq_en_q   <= cfg_wdata[NIRQ-1:0];
        CFG_SENSE:  irq_edge_q <= cfg_wdata[NIRQ-1:0];
        default:    ;
      endcase
    end
  end

  irq_sense_chan #(.SYNC_STAGES(SYNC_STAGES)) u_nmi (
    .clk(clk), .rst_n(rst_n), .pin_n(nmi_n), .edge_mode(1'b1),
    .wr_status(1'b0), .wr_bit(1'b1),
    .ack_clr(handshake && out_idx == '0), .flag(nmi_flag)
  );

  assign pend[0] = nmi_flag;
  assign hi[0]   = 1'b1;

  genvar k;
  generate
    for (k = 0; k < NIRQ; k++) begin : g_irq
      irq_sense_chan #(.SYNC_STAGES(SYNC_STAGES)) u_chan (
        .clk(clk), .rst_n(rst_n), .pin_n(irq_n[k]), .edge_mode(irq_edge_q[k]),
        .wr_status(wr_status), .wr_bit(cfg_wdata[k]),
        .ack_clr(1'b0), .flag(irq_flag_q[k])
      );
      assign pend[1+k] = irq_flag_q[k] & irq_en_q[k];
      assign hi[1+k]   = prio_q[irq_prio_bit(k)];
    end
    for (k = 0; k < NSRC; k++) begin : g_mod
      assign pend[1+NIRQ+k] = mod_req[k];
      assign hi[1+NIRQ+k]   = prio_q[IRQ_GRPS + k / SRC_PER_GRP];
    end
  endgenerate

  assign lo_ok = ~cpu_i;
  assign hi_ok = mode_ue ? ~cpu_i : ~(cpu_i & cpu_ui);

  irq_prio_arb #(.N(NALL), .IDX_W(IDX_W)) u_arb (
    .pend(pend), .hi(hi), .lo_ok(lo_ok), .hi_ok(hi_ok),
    .allowed(allowed), .win_valid(win_valid), .win_idx(win_idx)
  );

  irq_vec_hold #(.N(NALL), .IDX_W(IDX_W)) u_hold (
    .clk(clk), .rst_n(rst_n), .allowed(allowed),
    .win_valid(win_valid), .win_idx(win_idx), .ready(int_ready),
    .out_valid(int_valid), .out_idx(out_idx), .handshake(handshake)
  );

  always_comb begin
    if (out_idx == '0)
      int_vector = VEC_W'(NMI_VEC);
    else if (int'(out_idx) <= NIRQ)
      int_vector = VEC_W'(IRQ_VEC_BASE + int'(out_idx) - 1);
    else
      int_vector = VEC_W'(MOD_VEC_BASE + int'(out_idx) - 1 - NIRQ);
  end

  // R2
  nmi_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (nmi_flag && !int_valid) |=> (int_valid && int_vector == VEC_W'(NMI_VEC)));

  // R8
  ue_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_ue && cpu_i) |=> (!int_valid || int_vector == VEC_W'(NMI_VEC)));

  // R9
  dual_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode_ue && cpu_i && cpu_ui) |=> (!int_valid || int_vector == VEC_W'(NMI_VEC)));
endmodule

// File: tb/irq_prio_ctrl_bench.sv
module irq_prio_ctrl_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic nmi_n = 1'b1;
  logic [5:0] irq_n = '1;
  logic [7:0] mod_req = '0;
  logic cpu_i = 1'b0, cpu_ui = 1'b0, mode_ue = 1'b0;
  logic cfg_we = 1'b0;
  logic [1:0] cfg_sel = '0;
  logic [7:0] cfg_wdata = '0;
  logic int_ready = 1'b0;
  logic int_valid;
  logic [7:0] int_vector, prio_q;
  logic [5:0] irq_en_q, irq_edge_q, irq_flag_q;

  int compared = 0;
  int mismatched = 0;
  int cycles = 0;

  always #10 clk = ~clk;

  irq_prio_ctrl u_irq_prio_ctrl (
    .clk(clk), .rst_n(rst_n), .nmi_n(nmi_n), .irq_n(irq_n), .mod_req(mod_req),
    .cpu_i(cpu_i), .cpu_ui(cpu_ui), .mode_ue(mode_ue),
    .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
    .int_valid(int_valid), .int_vector(int_vector), .int_ready(int_ready),
    .prio_q(prio_q), .irq_en_q(irq_en_q), .irq_edge_q(irq_edge_q),
    .irq_flag_q(irq_flag_q)
  );

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      mismatched++;
      $display("FAIL watchdog: run did not finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string tag, input int act, input int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic cfg_write(input logic [1:0] sel, input logic [7:0] data);
    cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = data;
    tick(1);
    cfg_we = 1'b0;
  endtask

  task automatic t_reset;
    chk("R1 valid", int_valid, 0);
    chk("R1 prio", prio_q, 0);
    chk("R1 enable", irq_en_q, 0);
    chk("R1 sense", irq_edge_q, 0);
    chk("R1 flags", irq_flag_q, 0);
  endtask

  task automatic t_fixed_order;
    mod_req[3] = 1'b1; mod_req[1] = 1'b1;
    tick(1);
    chk("R12 module latency valid", int_valid, 1);
    chk("R7 lowest vector wins", int_vector, 25);
    mod_req = '0; tick(1);
    chk("R11 withdrawn drops", int_valid, 0);
  endtask

  task automatic t_level_rank;
    cfg_write(2'd0, 8'h20);
    mod_req[0] = 1'b1; mod_req[3] = 1'b1;
    tick(1);
    chk("R6 high level wins", int_vector, 27);
    mod_req = '0; cfg_write(2'd0, 8'h00);
    tick(1);
  endtask

  task automatic t_hold;
    mod_req[2] = 1'b1; tick(1);
    chk("R10 first vector", int_vector, 26);
    mod_req[0] = 1'b1; tick(2);
    chk("R10 held against newer", int_vector, 26);
    chk("R10 still valid", int_valid, 1);
    int_ready = 1'b1; tick(1);
    chk("R12 idle after handshake", int_valid, 0);
    int_ready = 1'b0; tick(1);
    chk("R7 next winner", int_vector, 24);
    mod_req = '0; tick(1);
    chk("R11 cleared", int_valid, 0);
  endtask

  task automatic t_withdraw;
    mod_req[4] = 1'b1; tick(1);
    chk("R11 start", int_vector, 28);
    mod_req[4] = 1'b0; mod_req[5] = 1'b1; tick(1);
    chk("R11 replaced", int_vector, 29);
    mod_req[5] = 1'b0; tick(1);
    chk("R11 none left", int_valid, 0);
  endtask

  task automatic t_mask_ue;
    cfg_write(2'd0, 8'h10);
    mode_ue = 1'b1; cpu_i = 1'b1; cpu_ui = 1'b0;
    mod_req[0] = 1'b1; tick(2);
    chk("R8 high masked", int_valid, 0);
    cpu_i = 1'b0; tick(1);
    chk("R8 unmasked", int_vector, 24);
    mod_req = '0; mode_ue = 1'b0; tick(1);
    cfg_write(2'd0, 8'h00);
  endtask

  task automatic t_mask_two_level;
    cfg_write(2'd0, 8'h10);
    cpu_i = 1'b1; cpu_ui = 1'b0;
    mod_req[2] = 1'b1; tick(2);
    chk("R9 low masked by I", int_valid, 0);
    mod_req[0] = 1'b1; tick(1);
    chk("R9 high passes", int_vector, 24);
    cpu_ui = 1'b1; tick(1);
    chk("R9 both masked", int_valid, 0);
    cpu_i = 1'b0; tick(1);
    chk("R9 UI alone no mask", int_vector, 24);
    mod_req = '0; cpu_ui = 1'b0; tick(1);
    cfg_write(2'd0, 8'h00);
  endtask

  task automatic t_irq_level;
    cfg_write(2'd1, 8'h02);
    irq_n[1] = 1'b0; tick(3);
    chk("R3 level flag set", irq_flag_q[1], 1);
    tick(1);
    chk("R12 pin latency", int_vector, 13);
    cfg_write(2'd3, 8'h00);
    chk("R3 level resets flag", irq_flag_q[1], 1);
    irq_n[1] = 1'b1; tick(3);
    cfg_write(2'd3, 8'h00);
    chk("R4 write zero clears", irq_flag_q[1], 0);
    tick(1);
    chk("R11 cleared irq drops", int_valid, 0);
    cfg_write(2'd1, 8'h00);
  endtask

  task automatic t_irq_edge;
    cfg_write(2'd2, 8'h04);
    irq_n[2] = 1'b0; tick(3);
    chk("R3 edge flag set", irq_flag_q[2], 1);
    tick(1);
    chk("R5 disabled not presented", int_valid, 0);
    cfg_write(2'd3, 8'h3F);
    chk("R4 write one no effect", irq_flag_q[2], 1);
    cfg_write(2'd3, 8'h00);
    tick(3);
    chk("R3 held low no re-set", irq_flag_q[2], 0);
    irq_n[2] = 1'b1; tick(3);
    cfg_write(2'd1, 8'h04);
    irq_n[2] = 1'b0; tick(1);
    irq_n[2] = 1'b1; tick(3);
    chk("R5 enabled presented", int_vector, 14);
    cfg_write(2'd3, 8'h00);
    cfg_write(2'd1, 8'h00);
    cfg_write(2'd2, 8'h00);
    tick(3);
  endtask

  task automatic t_nmi;
    cfg_write(2'd0, 8'h10);
    mod_req[0] = 1'b1; cpu_i = 1'b1; cpu_ui = 1'b1;
    tick(1);
    chk("R9 all masked", int_valid, 0);
    nmi_n = 1'b0; tick(4);
    chk("R2 nmi valid", int_valid, 1);
    chk("R2 nmi vector", int_vector, 7);
    int_ready = 1'b1; tick(1);
    int_ready = 1'b0;
    chk("R12 idle after nmi", int_valid, 0);
    tick(1);
    chk("R2 nmi cleared", int_valid, 0);
    cpu_i = 1'b0; cpu_ui = 1'b0; tick(1);
    chk("R9 unmask", int_vector, 24);
    nmi_n = 1'b1; mod_req = '0; tick(1);
    cfg_write(2'd0, 8'h00);
  endtask

  initial begin
    tick(2);
    rst_n = 1'b1;
    tick(1);
    t_reset;
    t_fixed_order;
    t_level_rank;
    t_hold;
    t_withdraw;
    t_mask_ue;
    t_mask_two_level;
    t_irq_level;
    t_irq_edge;
    t_nmi;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule